// File: doc/BRIEF.md
# Output-Compare Bank with Forced Actions

This block holds five output-compare channels that share one free-running 16-bit counter. The counter advances by one on every cycle where the `tick` input is high. On each such step, every channel compares the new counter value with its own 16-bit compare register. When the two are equal, the channel sets its status flag and carries out its programmed action on an output pin.

Software uses a byte-wide register bus to program the compare values, the channel modes and the pin groups. The same bus clears flags and reads the counter. A force register lets software launch any channel's pin action early. The forced action waits for the next counter step and leaves the flag untouched.

Channel 1 works differently from the others. It has no mode field. Instead it drives a group of pins chosen by a mask register, and each chosen pin takes the value held in a data register. Channel 1 wins over channels 2 to 5 when both act on the same pin in the same step.

Top module: `oc_bank`

Register map (byte addresses; the field bits 7:3 stand for channel 1 down to channel 5, or for pins 4 down to 0):
- 0x00: force strobes.
- 0x01: channel-1 pin mask.
- 0x02: channel-1 pin data.
- 0x03: modes for channels 2 to 5, in bits [7:6], [5:4], [3:2] and [1:0] respectively.
- 0x04: flags.
- 0x05 and 0x06: counter high byte and low byte.
- 0x08 + 2·(c−1) and the next address: compare high byte and low byte of channel c.

## Requirements
- R1: After reset the counter reads 0, all pins and flags are 0, the force, mask, data and mode registers read 0x00, and every compare register reads 0xFFFF.
- R2: The counter increments by one on each cycle with `tick` high, holds its value otherwise, and wraps from 0xFFFF to 0x0000.
- R3: When the counter value produced by a step equals a channel's compare value, that channel's flag is set at that same step. Flags never rise on a cycle without `tick`.
- R4: Writing 1 to a flag bit at 0x04 clears that flag, and writing 0 leaves it unchanged. A match in the same cycle as the clear leaves the flag set.
- R5: Channels 2 to 5 apply their 2-bit mode to their own pin (channel c drives pin 5−c) when they fire. The codes are 00 no change, 01 toggle, 10 drive 0 and 11 drive 1. A match sets the flag even when the mode is 00.
- R6: A 1 written to force bit 7−(c−1) makes channel c perform its pin action at the next counter step, and not before. The force does not set the flag. The force register always reads 0x00, and a force is consumed by the step that applies it.
- R7: A force and a match on the same channel at the same step produce a single action, so a toggling pin changes once.
- R8: When channel 1 fires, each pin whose mask bit is 1 takes the matching data bit, and pins with a mask bit of 0 keep their value. Pin 4 is driven only through channel 1. Bits 2:0 of the mask and data registers read 0.
- R9: When channel 1 and one of channels 2 to 5 act on the same pin at the same step, the pin takes channel 1's data bit.
- R10: A force written in the same cycle as a counter step is applied at the following step, not at that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter step enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_o | output | 5 | Compare output pins; bit 4 is channel 1's own pin, bit 0 is channel 5's |
| flag_o | output | 5 | Channel flags; bit 4 is channel 1, bit 0 is channel 5 |

## Verification
The bench builds the block with its default 16-bit counter and five channels. A full counter period is then 65,536 steps, short enough to run completely. This lets a compare value of 0x0000 be hit exactly at the wrap from 0xFFFF. With all five channels present, a single step can combine a channel-1 masked write with a mode action on the same pin. It can also combine a force and a match on the same toggling channel.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int NCH     = 5;
    localparam int DW      = 8;
    localparam int AW      = 5;
    localparam int CW      = 16;
    localparam int FLD_LSB = DW - NCH;
    localparam int MODE_W  = 2 * (NCH - 1);

    localparam logic [AW-1:0] A_FORCE    = 5'h00;
    localparam logic [AW-1:0] A_MASK     = 5'h01;
    localparam logic [AW-1:0] A_DATA     = 5'h02;
    localparam logic [AW-1:0] A_MODE     = 5'h03;
    localparam logic [AW-1:0] A_FLAG     = 5'h04;
    localparam logic [AW-1:0] A_CNT_HI   = 5'h05;
    localparam logic [AW-1:0] A_CNT_LO   = 5'h06;
    localparam logic [AW-1:0] A_CMP_BASE = 5'h08;

    typedef enum logic [1:0] {
        OC_KEEP = 2'b00,
        OC_TOG  = 2'b01,
        OC_LOW  = 2'b10,
        OC_HIGH = 2'b11
    } oc_mode_e;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } oc_bus_t;

    // Field bit j (register bit j+FLD_LSB) belongs to channel NCH-j.
    function automatic logic [AW-1:0] cmp_hi_addr(input int j);
        return A_CMP_BASE + AW'(2 * (NCH - 1 - j));
    endfunction

    function automatic logic [NCH-1:0] field_of(input logic [DW-1:0] b);
        return b[DW-1 -: NCH];
    endfunction

    function automatic logic apply_mode(input oc_mode_e m, input logic cur);
        case (m)
            OC_TOG:  return ~cur;
            OC_LOW:  return 1'b0;
            OC_HIGH: return 1'b1;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/oc_counter.sv
module oc_counter
    import oc_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next
);
    assign cnt_next = cnt_q + W'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/oc_cmp_reg.sv
module oc_cmp_reg
    import oc_pkg::*;
#(
    parameter logic [AW-1:0] HI_ADDR = A_CMP_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  oc_bus_t       bus,
    input  logic [CW-1:0] cnt_next,
    output logic [CW-1:0] cmp_q,
    output logic          match
);
    localparam logic [AW-1:0] LO_ADDR = HI_ADDR + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
        end else if (bus.wr) begin
            if (bus.addr == HI_ADDR) cmp_q[CW-1:DW] <= bus.wdata;
            if (bus.addr == LO_ADDR) cmp_q[DW-1:0]  <= bus.wdata;
        end
    end

    assign match = (cnt_next == cmp_q);
endmodule

// File: rtl/oc_pin_ctl.sv
module oc_pin_ctl
    import oc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    fire,
    input  logic [NCH-1:0]    mask,
    input  logic [NCH-1:0]    data,
    input  logic [MODE_W-1:0] mode,
    output logic [NCH-1:0]    pin_q
);
    logic [NCH-1:0] pin_n;
    logic           lead_fire;

    assign lead_fire = fire[NCH-1];

    for (genvar j = 0; j < NCH; j++) begin : g_pin
        if (j == NCH - 1) begin : g_lead
            // Pin driven only by channel 1's masked group.
            assign pin_n[j] = (lead_fire && mask[j]) ? data[j] : pin_q[j];
        end else begin : g_mode
            logic own_val;
            assign own_val  = apply_mode(oc_mode_e'(mode[2*j+1 -: 2]), pin_q[j]);
            assign pin_n[j] = (lead_fire && mask[j]) ? data[j]
                            : fire[j]                ? own_val
                            :                          pin_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_n;
    end
endmodule

// File: rtl/oc_bank.sv
module oc_bank
    import oc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [NCH-1:0] pin_o,
    output logic [NCH-1:0] flag_o
);
    oc_bus_t bus;
    assign bus = '{wr: wr_en, addr: addr, wdata: wdata};

    logic [CW-1:0]     cnt_q, cnt_next;
    logic [CW-1:0]     cmp_q [NCH];
    logic [NCH-1:0]    match, fire, force_pend, mask_q, data_q, flag_q, wfld;
    logic [MODE_W-1:0] mode_q;
    logic              wr_force, wr_mask, wr_data, wr_mode, wr_flag;

    oc_counter #(.W(CW)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    for (genvar j = 0; j < NCH; j++) begin : g_ch
        oc_cmp_reg #(.HI_ADDR(cmp_hi_addr(j))) i_cmp (
            .clk      (clk),
            .rst      (rst),
            .bus      (bus),
            .cnt_next (cnt_next),
            .cmp_q    (cmp_q[j]),
            .match    (match[j])
        );
    end

    assign wfld     = field_of(wdata);
    assign wr_force = wr_en && (addr == A_FORCE);
    assign wr_mask  = wr_en && (addr == A_MASK);
    assign wr_data  = wr_en && (addr == A_DATA);
    assign wr_mode  = wr_en && (addr == A_MODE);
    assign wr_flag  = wr_en && (addr == A_FLAG);

    // A pending force is consumed by the step; one written during a step waits for the next.
    assign fire = tick ? (match | force_pend) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            force_pend <= '0;
            mask_q     <= '0;
            data_q     <= '0;
            mode_q     <= '0;
            flag_q     <= '0;
        end else begin
            if (tick)          force_pend <= wr_force ? wfld : '0;
            else if (wr_force) force_pend <= force_pend | wfld;
            if (wr_mask) mask_q <= wfld;
            if (wr_data) data_q <= wfld;
            if (wr_mode) mode_q <= wdata;
            flag_q <= (flag_q & ~(wr_flag ? wfld : '0)) | (tick ? match : '0);
        end
    end

    oc_pin_ctl i_pins (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .mask  (mask_q),
        .data  (data_q),
        .mode  (mode_q),
        .pin_q (pin_o)
    );

    assign flag_o = flag_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_MASK:   rdata = {mask_q, {FLD_LSB{1'b0}}};
            A_DATA:   rdata = {data_q, {FLD_LSB{1'b0}}};
            A_MODE:   rdata = mode_q;
            A_FLAG:   rdata = {flag_q, {FLD_LSB{1'b0}}};
            A_CNT_HI: rdata = cnt_q[CW-1:DW];
            A_CNT_LO: rdata = cnt_q[DW-1:0];
            default: begin
                for (int j = 0; j < NCH; j++) begin
                    if (addr == cmp_hi_addr(j))          rdata = cmp_q[j][CW-1:DW];
                    if (addr == cmp_hi_addr(j) + AW'(1)) rdata = cmp_q[j][DW-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/oc_bank_chk.sv
module oc_bank_chk
    import oc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wdata,
    input logic [DW-1:0]  rdata,
    input logic [CW-1:0]  cnt,
    input logic [NCH-1:0] pin_o,
    input logic [NCH-1:0] flag_o
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_o == '0 && flag_o == '0 && cnt == '0));

    // R2
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + CW'(1)));

    // R2
    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R3
    a_r3_flags_rise_on_step: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ((flag_o & ~$past(flag_o)) == '0));

    // R6
    a_r6_pins_move_on_step: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pin_o));

    // R4
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_FLAG && !tick) |=> ((flag_o & $past(field_of(wdata))) == '0));

    // R6
    a_r6_force_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == A_FORCE) |-> (rdata == '0));
endmodule

bind oc_bank oc_bank_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .cnt    (cnt_q),
    .pin_o  (pin_o),
    .flag_o (flag_o)
);

// File: tb/test_oc_bank.sv
module test_oc_bank;
    import oc_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] pin_o, flag_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    oc_bank i_oc_bank (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pin_o  (pin_o),
        .flag_o (flag_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic steps(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic step_with_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_cmp(input int ch, input logic [15:0] v);
        wr(A_CMP_BASE + AW'(2 * (ch - 1)), v[15:8]);
        wr(A_CMP_BASE + AW'(2 * (ch - 1) + 1), v[7:0]);
    endtask

    function automatic logic [NCH-1:0] fld(input logic [DW-1:0] b);
        return b[7:3];
    endfunction

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 pins", pin_o, 0);
        chk("R1 flags", flag_o, 0);
        rd(A_FORCE, v); chk("R1 force reg", v, 0);
        rd(A_MASK, v);  chk("R1 mask reg", v, 0);
        rd(A_DATA, v);  chk("R1 data reg", v, 0);
        rd(A_MODE, v);  chk("R1 mode reg", v, 0);
        rd(A_CNT_LO, v); chk("R1 counter", v, 0);
        rd(5'h08, v);   chk("R1 cmp1 high", v, 8'hFF);
        rd(5'h11, v);   chk("R1 cmp5 low", v, 8'hFF);
    endtask

    task automatic t_count();
        logic [DW-1:0] v;
        steps(5);
        rd(A_CNT_LO, v); chk("R2 five steps", v, 5);
        repeat (3) @(negedge clk);
        rd(A_CNT_LO, v); chk("R2 hold without tick", v, 5);
    endtask

    task automatic t_match();
        wr(A_MODE, 8'h40);
        set_cmp(2, 16'd8);
        steps(2);
        chk("R3 no flag before match", flag_o, 0);
        chk("R5 no pin before match", pin_o, 0);
        steps(1);
        chk("R3 flag on match", flag_o, 5'b01000);
        chk("R5 toggle on match", pin_o, 5'b01000);
    endtask

    task automatic t_flag_clear();
        wr(A_FLAG, 8'h00);
        chk("R4 write zero keeps flag", flag_o, 5'b01000);
        wr(A_FLAG, 8'h40);
        chk("R4 write one clears", flag_o, 0);
        set_cmp(2, 16'd10);
        steps(1);
        step_with_write(A_FLAG, 8'h40);
        chk("R4 set wins over clear", flag_o, 5'b01000);
        chk("R5 second toggle", pin_o, 5'b00000);
    endtask

    task automatic t_modes();
        set_cmp(3, 16'd12);
        set_cmp(4, 16'd12);
        set_cmp(5, 16'd12);
        wr(A_MODE, 8'h7C);
        steps(2);
        chk("R5 high/high/keep pins", pin_o, 5'b00110);
        chk("R5 flag with mode keep", flag_o, 5'b01111);
        wr(A_MODE, 8'h78);
        set_cmp(4, 16'd13);
        steps(1);
        chk("R5 drive low", pin_o, 5'b00100);
        wr(A_FLAG, 8'hF8);
        chk("R4 clear all", flag_o, 0);
    endtask

    task automatic t_force();
        logic [DW-1:0] v;
        wr(A_MODE, 8'h7B);
        wr(A_FORCE, 8'h08);
        rd(A_FORCE, v); chk("R6 force reads zero", v, 0);
        repeat (2) @(negedge clk);
        chk("R6 no action before step", pin_o, 5'b00100);
        steps(1);
        chk("R6 forced action", pin_o, 5'b00101);
        chk("R6 no flag on force", flag_o, 0);
        step_with_write(A_FORCE, 8'h40);
        chk("R10 not applied at same step", pin_o, 5'b00101);
        steps(1);
        chk("R10 applied at next step", pin_o, 5'b01101);
        steps(1);
        chk("R6 force consumed", pin_o, 5'b01101);
        chk("R6 still no flag", flag_o, 0);
    endtask

    task automatic t_toggle_both();
        set_cmp(2, 16'd18);
        wr(A_FORCE, 8'h40);
        steps(1);
        chk("R7 single toggle", pin_o, 5'b00101);
        chk("R7 match flag kept", flag_o, 5'b01000);
        wr(A_FLAG, 8'hF8);
    endtask

    task automatic t_lead();
        logic [DW-1:0] v;
        wr(A_MASK, 8'hFF);
        rd(A_MASK, v); chk("R8 mask low bits zero", v, 8'hF8);
        wr(A_DATA, 8'hFF);
        rd(A_DATA, v); chk("R8 data low bits zero", v, 8'hF8);
        wr(A_MASK, 8'hB0);
        wr(A_DATA, 8'h90);
        wr(A_FORCE, 8'hA0);
        steps(1);
        chk("R9 channel 1 wins on shared pin", pin_o, 5'b10011);
        chk("R8 forced group no flag", flag_o, 0);
        set_cmp(1, 16'd20);
        wr(A_MASK, 8'h88);
        wr(A_DATA, 8'h00);
        steps(1);
        chk("R8 masked pins only", pin_o, 5'b00010);
        chk("R3 channel 1 flag", flag_o, 5'b10000);
        wr(A_FLAG, 8'hF8);
    endtask

    task automatic t_wrap();
        logic [DW-1:0] hi, lo;
        int left;
        rd(A_CNT_HI, hi);
        rd(A_CNT_LO, lo);
        chk("R2 counter before wrap", {hi, lo}, 20);
        set_cmp(5, 16'h0000);
        left = 65536 - 20;
        steps(left);
        rd(A_CNT_HI, hi);
        rd(A_CNT_LO, lo);
        chk("R2 wrapped to zero", {hi, lo}, 0);
        chk("R3 match at wrap", flag_o, 5'b00001);
        chk("R5 high at wrap", pin_o, 5'b00011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_match();
        t_flag_clear();
        t_modes();
        t_force();
        t_toggle_both();
        t_lead();
        t_wrap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule